// File: doc/BRIEF.md
# Machine-Mode Trap Entry and Return Controller

This block decides, each cycle, whether a machine-mode-only 32-bit core must leave its normal instruction flow. It watches the instruction word being executed, that instruction's address, the jump decision and jump target from the execute logic, a timer interrupt line, and the current trap-related control registers (status, interrupt enable, trap vector, exception PC and cause). When an enabled timer interrupt is pending, or the instruction is an environment call or breakpoint, it requests a fetch redirect to the trap vector. When the instruction is a machine-mode return, it requests a redirect back to the saved exception PC.

In the same cycle as any redirect, the block drives a write bundle carrying the new status, exception PC and cause values, together with one write enable. The register file applies all three fields on the next clock edge as one atomic update. The block is purely combinational: it holds no state, and it has no data stream, so every pin is a plain control or status signal with no handshake.

Only the direct (non-vectored) trap vector is used. There is a single interrupt source.

Top module: `trap_ctrl`

## Requirements
- R1: A timer interrupt is taken only when `timer_irq`=1, status bit 3 (global enable)=1 and enable-mask bit 7=1. When it is taken, `redirect`=1 and `redirect_pc` equals `csr_mtvec`.
- R2: On a taken interrupt, `mepc_nxt` equals `jump_target` when `jump_taken`=1, and `pc` otherwise.
- R3: On a taken interrupt, `mcause_nxt` is 0x80000007: bit 31 is set and the code is 7.
- R4: When `instr` is 0x00000073 (environment call) or 0x00100073 (breakpoint) and no interrupt is taken, the block traps to `csr_mtvec` with `mepc_nxt`=`pc`. `mcause_nxt` is 11 for the call and 3 for the breakpoint, with bit 31 clear.
- R5: On any trap entry, `mstatus_nxt` copies old bit 3 into bit 7, clears bit 3, sets bits 12:11 to 2'b11, and leaves every other bit unchanged.
- R6: When `instr` is 0x30200073 (return) and no interrupt is taken, `redirect_pc` equals `csr_mepc`. `mstatus_nxt` copies old bit 7 into bit 3, sets bit 7 to 1, sets bits 12:11 to 2'b11, and keeps the other bits. `mepc_nxt` and `mcause_nxt` equal their inputs.
- R7: A taken interrupt has priority over an environment call, a breakpoint or a return in the same cycle. `csr_wr_en` is 1 exactly in cycles where `redirect` is 1.
- R8: With no event (no qualified interrupt and any other instruction), `redirect` and `csr_wr_en` are 0 and `redirect_pc` is 0. `mstatus_nxt`, `mepc_nxt` and `mcause_nxt` equal their inputs, so a masked interrupt has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word currently executing |
| pc | input | XLEN | Address of that instruction |
| jump_taken | input | 1 | Execute logic is taking a jump or branch this cycle |
| jump_target | input | XLEN | Target of that jump or branch |
| timer_irq | input | 1 | Pending timer interrupt |
| csr_mstatus | input | XLEN | Current status register |
| csr_mie | input | XLEN | Current interrupt enable mask |
| csr_mtvec | input | XLEN | Trap vector (handler address) |
| csr_mepc | input | XLEN | Saved exception PC |
| csr_mcause | input | XLEN | Current cause register |
| redirect | output | 1 | Fetch must go to redirect_pc next |
| redirect_pc | output | XLEN | Handler or return address |
| csr_wr_en | output | 1 | Apply the three next-values below |
| mstatus_nxt | output | XLEN | New status value |
| mepc_nxt | output | XLEN | New exception PC value |
| mcause_nxt | output | XLEN | New cause value |

## Verification
The bench goes after several corner cases:
- An interrupt that arrives together with an environment call or a return. A design with the priority reversed would save the wrong cause, or return instead of trapping.
- An interrupt during a taken jump. A design that ignored the jump would resume at the wrong instruction.
- Interrupts masked by either enable bit alone. Here a loose qualification would redirect spuriously.
- Return with saved-enable values of both 0 and 1, plus status words with unrelated bits set. These catch swapped or clobbered status fields.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int ILEN = 32;
  localparam logic [ILEN-1:0] INSN_ENV_CALL  = 32'h0000_0073;
  localparam logic [ILEN-1:0] INSN_ENV_BREAK = 32'h0010_0073;
  localparam logic [ILEN-1:0] INSN_M_RETURN  = 32'h3020_0073;

  localparam int ST_GIE   = 3;
  localparam int ST_PGIE  = 7;
  localparam int ST_PRV_LO = 11;
  localparam int ST_PRV_HI = 12;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_IRQ  = 2'd1,
    EV_EXC  = 2'd2,
    EV_RET  = 2'd3
  } trap_ev_e;
endpackage

// File: rtl/trap_event_sel.sv
module trap_event_sel
  import trap_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int IRQ_EN_BIT = 7,
  parameter int CODE_CALL  = 11,
  parameter int CODE_BRK   = 3,
  parameter int CODE_TIMER = 7
) (
  input  logic [ILEN-1:0] instr,
  input  logic            timer_irq,
  input  logic [XLEN-1:0] mstatus,
  input  logic [XLEN-1:0] mie,
  output trap_ev_e        ev,
  output logic [XLEN-2:0] code
);
  localparam int CW = XLEN - 1;

  logic irq_ok;
  assign irq_ok = timer_irq && mstatus[ST_GIE] && mie[IRQ_EN_BIT];

  always_comb begin
    ev   = EV_NONE;
    code = '0;
    if (irq_ok) begin
      ev   = EV_IRQ;
      code = CW'(CODE_TIMER);
    end else if (instr == INSN_ENV_CALL) begin
      ev   = EV_EXC;
      code = CW'(CODE_CALL);
    end else if (instr == INSN_ENV_BREAK) begin
      ev   = EV_EXC;
      code = CW'(CODE_BRK);
    end else if (instr == INSN_M_RETURN) begin
      ev = EV_RET;
    end
  end

  always_comb begin
    // R8
    masked_irq_chk: assert (irq_ok || ev != EV_IRQ);
  end
endmodule

// File: rtl/trap_state_calc.sv
module trap_state_calc
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  trap_ev_e        ev,
  input  logic [XLEN-2:0] code,
  input  logic [XLEN-1:0] pc,
  input  logic            jump_taken,
  input  logic [XLEN-1:0] jump_target,
  input  logic [XLEN-1:0] mstatus,
  input  logic [XLEN-1:0] mtvec,
  input  logic [XLEN-1:0] mepc,
  input  logic [XLEN-1:0] mcause,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc,
  output logic            wr_en,
  output logic [XLEN-1:0] mstatus_n,
  output logic [XLEN-1:0] mepc_n,
  output logic [XLEN-1:0] mcause_n
);
  always_comb begin
    redirect    = 1'b0;
    redirect_pc = '0;
    wr_en       = 1'b0;
    mstatus_n   = mstatus;
    mepc_n      = mepc;
    mcause_n    = mcause;
    unique case (ev)
      EV_IRQ, EV_EXC: begin
        redirect    = 1'b1;
        wr_en       = 1'b1;
        redirect_pc = mtvec;
        mstatus_n[ST_PGIE] = mstatus[ST_GIE];
        mstatus_n[ST_GIE]  = 1'b0;
        mstatus_n[ST_PRV_HI:ST_PRV_LO] = 2'b11;
        mcause_n = {ev == EV_IRQ, code};
        mepc_n   = (ev == EV_IRQ && jump_taken) ? jump_target : pc;
      end
      EV_RET: begin
        redirect    = 1'b1;
        wr_en       = 1'b1;
        redirect_pc = mepc;
        mstatus_n[ST_GIE]  = mstatus[ST_PGIE];
        mstatus_n[ST_PGIE] = 1'b1;
        mstatus_n[ST_PRV_HI:ST_PRV_LO] = 2'b11;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] pc,
  input  logic            jump_taken,
  input  logic [XLEN-1:0] jump_target,
  input  logic            timer_irq,
  input  logic [XLEN-1:0] csr_mstatus,
  input  logic [XLEN-1:0] csr_mie,
  input  logic [XLEN-1:0] csr_mtvec,
  input  logic [XLEN-1:0] csr_mepc,
  input  logic [XLEN-1:0] csr_mcause,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc,
  output logic            csr_wr_en,
  output logic [XLEN-1:0] mstatus_nxt,
  output logic [XLEN-1:0] mepc_nxt,
  output logic [XLEN-1:0] mcause_nxt
);
  trap_ev_e        ev;
  logic [XLEN-2:0] code;

  trap_event_sel #(.XLEN(XLEN)) u_sel (
    .instr     (instr),
    .timer_irq (timer_irq),
    .mstatus   (csr_mstatus),
    .mie       (csr_mie),
    .ev        (ev),
    .code      (code)
  );

  trap_state_calc #(.XLEN(XLEN)) u_calc (
    .ev          (ev),
    .code        (code),
    .pc          (pc),
    .jump_taken  (jump_taken),
    .jump_target (jump_target),
    .mstatus     (csr_mstatus),
    .mtvec       (csr_mtvec),
    .mepc        (csr_mepc),
    .mcause      (csr_mcause),
    .redirect    (redirect),
    .redirect_pc (redirect_pc),
    .wr_en       (csr_wr_en),
    .mstatus_n   (mstatus_nxt),
    .mepc_n      (mepc_nxt),
    .mcause_n    (mcause_nxt)
  );

  always_comb begin
    // R7
    wr_with_redirect_chk: assert (csr_wr_en == redirect);
    // R5
    entry_gie_clear_chk: assert (!(ev == EV_IRQ || ev == EV_EXC) ||
      (!mstatus_nxt[ST_GIE] && mstatus_nxt[ST_PGIE] == csr_mstatus[ST_GIE]));
    // R6
    ret_target_chk: assert (ev != EV_RET || redirect_pc == csr_mepc);
    // R3
    cause_kind_chk: assert (!(ev == EV_IRQ || ev == EV_EXC) ||
      mcause_nxt[XLEN-1] == (ev == EV_IRQ));
    // R8
    idle_quiet_chk: assert (redirect || (mepc_nxt == csr_mepc && mcause_nxt == csr_mcause));
  end
endmodule

// File: tb/trap_ctrl_tb_top.sv
module trap_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] I_CALL = 32'h0000_0073;
  localparam logic [31:0] I_BRK  = 32'h0010_0073;
  localparam logic [31:0] I_RET  = 32'h3020_0073;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] instr, pc, jump_target, mstatus, mie, mtvec, mepc, mcause;
  logic jump_taken, timer_irq;
  logic redirect, csr_wr_en;
  logic [31:0] redirect_pc, mstatus_nxt, mepc_nxt, mcause_nxt;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  trap_ctrl dut_i (
    .instr(instr), .pc(pc), .jump_taken(jump_taken), .jump_target(jump_target),
    .timer_irq(timer_irq), .csr_mstatus(mstatus), .csr_mie(mie),
    .csr_mtvec(mtvec), .csr_mepc(mepc), .csr_mcause(mcause),
    .redirect(redirect), .redirect_pc(redirect_pc), .csr_wr_en(csr_wr_en),
    .mstatus_nxt(mstatus_nxt), .mepc_nxt(mepc_nxt), .mcause_nxt(mcause_nxt)
  );

  task automatic cmp(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Behavioural reference, evaluated on the falling edge after inputs settle.
  task automatic check_now();
    bit take_irq, is_call, is_brk, is_ret;
    logic [31:0] e_st, e_epc, e_cause, e_pc;
    bit e_rd;
    string tag;
    take_irq = timer_irq && mstatus[3] && mie[7];
    is_call  = (instr == I_CALL);
    is_brk   = (instr == I_BRK);
    is_ret   = (instr == I_RET);
    e_st = mstatus; e_epc = mepc; e_cause = mcause; e_pc = 32'h0; e_rd = 0;
    if (take_irq) begin
      tag = (is_call || is_brk || is_ret) ? "R7" : (jump_taken ? "R2" : "R1");
      e_rd = 1; e_pc = mtvec;
      e_epc = jump_taken ? jump_target : pc;
      e_cause = 32'h8000_0007;
    end else if (is_call || is_brk) begin
      tag = "R4";
      e_rd = 1; e_pc = mtvec; e_epc = pc;
      e_cause = is_call ? 32'd11 : 32'd3;
    end else if (is_ret) begin
      tag = "R6";
      e_rd = 1; e_pc = mepc;
      e_st[3] = mstatus[7]; e_st[7] = 1'b1; e_st[12:11] = 2'b11;
    end else begin
      tag = "R8";
    end
    if (take_irq || (!take_irq && (is_call || is_brk))) begin
      e_st[7] = mstatus[3]; e_st[3] = 1'b0; e_st[12:11] = 2'b11;
      cmp("R5", "mstatus_nxt", mstatus_nxt, e_st);
      if (take_irq) cmp("R3", "mcause_nxt", mcause_nxt, e_cause);
    end
    cmp(tag, "redirect", {31'b0, redirect}, {31'b0, e_rd});
    cmp("R7", "csr_wr_en", {31'b0, csr_wr_en}, {31'b0, e_rd});
    cmp(tag, "redirect_pc", redirect_pc, e_pc);
    cmp(tag, "mstatus_nxt", mstatus_nxt, e_st);
    cmp(tag, "mepc_nxt", mepc_nxt, e_epc);
    cmp(tag, "mcause_nxt", mcause_nxt, e_cause);
  endtask

  task automatic apply(logic [31:0] i, bit irq, logic [31:0] st, logic [31:0] en, bit jt);
    @(posedge clk); #1;
    instr = i; timer_irq = irq; mstatus = st; mie = en; jump_taken = jt;
    @(negedge clk);
    check_now();
  endtask

  initial begin
    instr = 32'h0; pc = 32'h0; jump_taken = 0; jump_target = 32'h0; timer_irq = 0;
    mstatus = 0; mie = 0; mtvec = 0; mepc = 0; mcause = 0;
    @(negedge clk);
    check_now();  // all-zero start: idle outputs (R8)
    pc = 32'h0000_1000; jump_target = 32'h0000_2000; mtvec = 32'h0000_0800;
    mepc = 32'h0000_3004; mcause = 32'h0000_0005;
    apply(32'h0000_0013, 1, 32'h0000_0008, 32'h80, 0);   // R1 plain interrupt
    apply(32'h0000_0013, 1, 32'h0000_0008, 32'h80, 1);   // R2 during jump
    apply(32'h0000_0013, 1, 32'h0000_0000, 32'h80, 0);   // R8 masked by global
    apply(32'h0000_0013, 1, 32'h0000_0008, 32'h00, 0);   // R8 masked by mask
    apply(I_CALL, 0, 32'h0000_0088, 32'h80, 1);          // R4 call, pc kept
    apply(I_BRK, 0, 32'h0000_0000, 32'h80, 0);           // R4 breakpoint
    apply(I_RET, 0, 32'h0000_0080, 32'h80, 0);           // R6 restore 1
    apply(I_RET, 0, 32'h0000_0008, 32'h00, 0);           // R6 restore 0
    apply(I_CALL, 1, 32'h0000_0008, 32'h80, 0);          // R7 irq beats call
    apply(I_RET, 1, 32'h0000_0088, 32'h80, 1);           // R7 irq beats return
    apply(I_RET, 0, 32'hFFFF_E777, 32'h80, 0);           // R6 other bits kept
    apply(I_BRK, 0, 32'hFFFF_E77F, 32'h80, 0);           // R5 other bits kept
    for (int k = 0; k < 400; k++) begin
      logic [31:0] pick;
      case ($urandom_range(0, 3))
        0: pick = I_CALL;
        1: pick = I_BRK;
        2: pick = I_RET;
        default: begin pick = $urandom; if (pick[6:0] == 7'h73) pick[6:0] = 7'h13; end
      endcase
      pc = $urandom; jump_target = $urandom; mtvec = $urandom;
      mepc = $urandom; mcause = $urandom;
      apply(pick, 1'($urandom), $urandom, $urandom, 1'($urandom));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule